// File: doc/BRIEF.md
# Processor Clock-Stop Sleep Controller

This block sits next to a 16/32-bit processor that can be stopped while keeping its state. It produces the processor's clock from the system clock. A sleep request is a supervisor-mode data write to an address that software chooses. From that write onward, the block counts processor bus cycles by watching the address strobe. When the cycle that fetches the halt instruction's immediate operand is over, the block holds the processor clock low. On a 16-bit bus this operand fetch is the first cycle after the write. On an 8-bit bus the operand takes two byte cycles, so one more cycle is counted.

While the clock is stopped, the block compares the pending interrupt level with a programmable wake level and raises a wake request when it is reached. An external restart input then brings the clock back. The enable that gates the clock changes only while the system clock is low. Because of this, the gated clock never carries a shortened high pulse, either when it stops or when it starts again. An active-low asynchronous reset clears the whole sequence and lets the clock run at once.

Top module: `clkstop_ctrl`

## Requirements
- R1: A counted sequence starts only from a bus cycle whose strobe falls (`bus_as_n` 1 then 0 on successive rising edges) while `bus_addr` equals `lp_addr` in all 24 bits, `bus_rw` is 0 (write) and `bus_fc` is 3'b101. Any other address, direction or function code leaves the block idle. This holds for every `lp_addr` from 24'h000000 to 24'hFFFFFF.
- R2: With `wide_bus` = 1, `sleeping` goes high on the first rising edge that samples `bus_as_n` high after the second counted strobe cycle. The matching write is the first counted cycle. Idle clocks between cycles do not count.
- R3: With `wide_bus` = 0, one more strobe cycle is needed: `sleeping` stays low after the second cycle ends and rises after the third cycle ends.
- R4: The high phase of `sys_clk` that begins at the edge raising `sleeping` still appears on `cpu_clk`. From the next rising edge on, `cpu_clk` stays low for as long as `sleeping` is high.
- R5: Let k be the first rising edge that samples `restart` high while asleep. `sleeping` falls at edge k+2, `cpu_clk` stays low through the high phase after that edge, and `cpu_clk` pulses again from edge k+3.
- R6: `restart` has no effect while the block is not asleep. `cpu_clk` keeps running, and a sequence already under way still stops at its normal point.
- R7: `rst_n` low immediately clears `sleeping`, makes `cpu_clk` follow `sys_clk`, and drops any partly counted sequence. A later operand fetch alone then does not stop the clock.
- R8: `wake_req` is registered. After a rising edge it is 1 exactly when, at that edge, the block was asleep and `irq_level` (binary level 0..7, active high) was greater than or equal to `wake_level`. It is 0 whenever the block was not asleep.
- R9: `cpu_clk` is never high while `sys_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| restart | input | 1 | Asynchronous request to resume the processor clock |
| bus_addr | input | 24 | Processor address bus |
| bus_rw | input | 1 | Bus direction, 1 = read, 0 = write |
| bus_fc | input | 3 | Processor function code |
| bus_as_n | input | 1 | Address strobe, active low |
| wide_bus | input | 1 | 1 = 16-bit data bus, 0 = 8-bit data bus |
| irq_level | input | 3 | Pending interrupt level, binary |
| lp_addr | input | 24 | Programmed sleep-request address |
| wake_level | input | 3 | Interrupt level that raises the wake request |
| cpu_clk | output | 1 | Gated processor clock |
| sleeping | output | 1 | Processor clock is stopped |
| wake_req | output | 1 | Interrupt level has reached the wake level while asleep |

## Verification
The properties assume that the bus inputs only change between system-clock edges, and that each strobe assertion and each negation lasts for at least one rising edge. The edge-based cycle count and the stop-point check both depend on this. The restart latency property assumes that `restart` is held for at least three rising edges. The stimulus meets these assumptions: every input changes 2 ns after a rising edge, every bus cycle keeps the strobe low for two edges and high for at least one, and restart is always held until the clock is running again. The stimulus also sweeps every function code and direction, and flips each address bit one at a time.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_COUNT  = 2'd1,
      ST_ASLEEP = 2'd2
   } seq_state_t;

   // Function code of a supervisor data access
   localparam logic [2:0] FC_SUP_DATA = 3'b101;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[0] <= RST_VAL;
            else         chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[i] <= RST_VAL;
            else         chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkstop_bus_watch.sv
module clkstop_bus_watch
   import clkstop_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rw,
   input  logic [2:0]        bus_fc,
   input  logic              bus_as_n,
   input  logic [ADDR_W-1:0] lp_addr,
   output logic              cyc_start,
   output logic              cyc_end,
   output logic              cyc_match
);
   logic as_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) as_prev <= 1'b1;
      else        as_prev <= bus_as_n;
   end

   // strobe edges seen on successive rising edges of the system clock
   assign cyc_start = as_prev & ~bus_as_n;
   assign cyc_end   = ~as_prev & bus_as_n;
   assign cyc_match = (bus_addr == lp_addr) && !bus_rw && (bus_fc == FC_SUP_DATA);
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
   import clkstop_pkg::*;
#(
   parameter int CNT_W         = 2,
   parameter int WIDE_CYCLES   = 2,
   parameter int NARROW_CYCLES = 3,
   parameter int LEVEL_W       = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wide_bus,
   input  logic               cyc_start,
   input  logic               cyc_end,
   input  logic               cyc_match,
   input  logic               restart_s,
   input  logic [LEVEL_W-1:0] irq_level,
   input  logic [LEVEL_W-1:0] wake_level,
   output logic               sleeping,
   output logic               wake_req
);
   localparam logic [CNT_W-1:0] WIDE_T   = CNT_W'(WIDE_CYCLES);
   localparam logic [CNT_W-1:0] NARROW_T = CNT_W'(NARROW_CYCLES);

   seq_state_t       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] target;
   logic             wake_q;

   assign target = wide_bus ? WIDE_T : NARROW_T;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (cyc_start && cyc_match) begin
               state_d = ST_COUNT;
               cnt_d   = CNT_W'(1);
            end
         end
         ST_COUNT: begin
            if (cyc_start) begin
               cnt_d = cnt_q + CNT_W'(1);
            end else if (cyc_end && (cnt_q >= target)) begin
               state_d = ST_ASLEEP;
               cnt_d   = '0;
            end
         end
         ST_ASLEEP: begin
            if (restart_s) state_d = ST_IDLE;
         end
         default: begin
            state_d = ST_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         wake_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         wake_q  <= (state_q == ST_ASLEEP) && (irq_level >= wake_level);
      end
   end

   assign sleeping = (state_q == ST_ASLEEP);
   assign wake_req = wake_q;
endmodule

// File: rtl/clkstop_clk_gate.sv
module clkstop_clk_gate #(
   parameter bit USE_LATCH = 1'b0
) (
   input  logic sys_clk,
   input  logic arst_n,
   input  logic run_req,
   output logic cpu_clk
);
   logic en;

   if (USE_LATCH) begin : g_latch
      // transparent only in the low phase of the system clock
      always_latch begin
         if (!arst_n)       en = 1'b1;
         else if (!sys_clk) en = run_req;
      end
   end else begin : g_flop
      always_ff @(negedge sys_clk or negedge arst_n) begin
         if (!arst_n) en <= 1'b1;
         else         en <= run_req;
      end
   end

   assign cpu_clk = sys_clk & en;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
   import clkstop_pkg::*;
#(
   parameter int ADDR_W        = 24,
   parameter int LEVEL_W       = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int WIDE_CYCLES   = 2,
   parameter int NARROW_CYCLES = 3,
   parameter bit GATE_LATCH    = 1'b0
) (
   input  logic               sys_clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_rw,
   input  logic [2:0]         bus_fc,
   input  logic               bus_as_n,
   input  logic               wide_bus,
   input  logic [LEVEL_W-1:0] irq_level,
   input  logic [ADDR_W-1:0]  lp_addr,
   input  logic [LEVEL_W-1:0] wake_level,
   output logic               cpu_clk,
   output logic               sleeping,
   output logic               wake_req
);
   localparam int MAX_CYC = (NARROW_CYCLES > WIDE_CYCLES) ? NARROW_CYCLES : WIDE_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WIDE_CYCLES < 1) begin : g_bad_wide
      $error("WIDE_CYCLES must be at least 1");
   end
   if (NARROW_CYCLES < WIDE_CYCLES) begin : g_bad_narrow
      $error("NARROW_CYCLES must not be below WIDE_CYCLES");
   end

   logic rst_n_int;
   logic restart_s;
   logic cyc_start, cyc_end, cyc_match;
   logic sleeping_i;

   clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk    (sys_clk),
      .arst_n (rst_n),
      .d      (1'b1),
      .q      (rst_n_int)
   );

   clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_restart_sync (
      .clk    (sys_clk),
      .arst_n (rst_n_int),
      .d      (restart),
      .q      (restart_s)
   );

   clkstop_bus_watch #(.ADDR_W(ADDR_W)) u_watch (
      .clk       (sys_clk),
      .rst_n     (rst_n_int),
      .bus_addr  (bus_addr),
      .bus_rw    (bus_rw),
      .bus_fc    (bus_fc),
      .bus_as_n  (bus_as_n),
      .lp_addr   (lp_addr),
      .cyc_start (cyc_start),
      .cyc_end   (cyc_end),
      .cyc_match (cyc_match)
   );

   clkstop_seq #(
      .CNT_W         (CNT_W),
      .WIDE_CYCLES   (WIDE_CYCLES),
      .NARROW_CYCLES (NARROW_CYCLES),
      .LEVEL_W       (LEVEL_W)
   ) u_seq (
      .clk        (sys_clk),
      .rst_n      (rst_n_int),
      .wide_bus   (wide_bus),
      .cyc_start  (cyc_start),
      .cyc_end    (cyc_end),
      .cyc_match  (cyc_match),
      .restart_s  (restart_s),
      .irq_level  (irq_level),
      .wake_level (wake_level),
      .sleeping   (sleeping_i),
      .wake_req   (wake_req)
   );

   clkstop_clk_gate #(.USE_LATCH(GATE_LATCH)) u_gate (
      .sys_clk (sys_clk),
      .arst_n  (rst_n),
      .run_req (~sleeping_i),
      .cpu_clk (cpu_clk)
   );

   assign sleeping = sleeping_i;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk (
   input logic sys_clk,
   input logic rst_n,
   input logic restart,
   input logic bus_as_n,
   input logic cpu_clk,
   input logic sleeping,
   input logic wake_req
);
   // entering sleep happens on the edge that sees the strobe negate
   p_stop_at_strobe_end_r2: assert property (@(posedge sys_clk) disable iff (!rst_n)
      $rose(sleeping) |-> ($past(bus_as_n) && !$past(bus_as_n, 2)));

   // high phase sampled at the falling edge: no pulse once asleep
   p_clk_held_low_r4: assert property (@(negedge sys_clk) disable iff (!rst_n)
      (sleeping && $past(sleeping)) |-> !cpu_clk);

   // clock runs through every high phase while awake
   p_clk_runs_awake_r9: assert property (@(negedge sys_clk) disable iff (!rst_n)
      (!sleeping && !$past(sleeping)) |-> cpu_clk);

   // leaving sleep follows a restart seen three edges earlier
   p_restart_latency_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
      $fell(sleeping) |-> $past(restart, 3));

   // wake request only after an asleep cycle
   p_wake_only_asleep_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
      wake_req |-> $past(sleeping));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
   .sys_clk  (sys_clk),
   .rst_n    (rst_n),
   .restart  (restart),
   .bus_as_n (bus_as_n),
   .cpu_clk  (cpu_clk),
   .sleeping (sleeping),
   .wake_req (wake_req)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart = 1'b0;
   logic [23:0] addr = 24'h0;
   logic        rw = 1'b1;
   logic [2:0]  fc = 3'd6;
   logic        as_n = 1'b1;
   logic        wide = 1'b1;
   logic [2:0]  irq = 3'd0;
   logic [23:0] lp = 24'hA53C0F;
   logic [2:0]  wl = 3'd5;
   logic        cpu_clk, sleeping, wake_req;

   int checks = 0;
   int errors = 0;
   int low_phase_bad = 0;
   bit done = 1'b0;

   clkstop_ctrl u0 (
      .sys_clk(clk), .rst_n(rst_n), .restart(restart), .bus_addr(addr),
      .bus_rw(rw), .bus_fc(fc), .bus_as_n(as_n), .wide_bus(wide),
      .irq_level(irq), .lp_addr(lp), .wake_level(wl),
      .cpu_clk(cpu_clk), .sleeping(sleeping), .wake_req(wake_req)
   );

   initial forever #4 clk = ~clk;

   // R9: sample every low phase of the system clock
   always @(negedge clk) begin
      #2;
      if (cpu_clk !== 1'b0) low_phase_bad++;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic bus_cyc(input logic [23:0] a, input logic r, input logic [2:0] f);
      step();
      addr = a; rw = r; fc = f; as_n = 1'b0;
      step();
      step();
      as_n = 1'b1; rw = 1'b1;
   endtask

   task automatic expect_stop(input string req);
      step();
      check(sleeping === 1'b1, req, "sleeping at stop edge", int'(sleeping), 1);
      check(cpu_clk === 1'b1, req, "last high phase kept", int'(cpu_clk), 1);
      step();
      check(cpu_clk === 1'b0, req, "clock held low", int'(cpu_clk), 0);
      step();
      check(cpu_clk === 1'b0, req, "clock still low", int'(cpu_clk), 0);
   endtask

   task automatic wake_up();
      restart = 1'b1;
      repeat (4) step();
      restart = 1'b0;
      step();
   endtask

   initial begin
      repeat (3) step();
      // reset state
      check(sleeping === 1'b0, "R7", "sleeping in reset", int'(sleeping), 0);
      check(cpu_clk === 1'b1, "R7", "clock runs in reset", int'(cpu_clk), 1);
      rst_n = 1'b1;
      repeat (4) step();
      check(wake_req === 1'b0, "R8", "wake after reset", int'(wake_req), 0);

      // R2: 16-bit bus, idle gap between write and operand fetch
      bus_cyc(lp, 1'b0, 3'd5);
      repeat (3) step();
      check(sleeping === 1'b0, "R2", "after write only", int'(sleeping), 0);
      check(cpu_clk === 1'b1, "R2", "clock after write", int'(cpu_clk), 1);
      bus_cyc(lp + 24'd4, 1'b1, 3'd6);
      check(sleeping === 1'b0, "R2", "before fetch end seen", int'(sleeping), 0);
      expect_stop("R4");

      // R8: sweep of interrupt levels while asleep
      for (int lv = 0; lv < 8; lv++) begin
         irq = 3'(lv);
         step();
         check(wake_req === (lv >= 5), "R8", "wake vs level", int'(wake_req), int'(lv >= 5));
      end
      irq = 3'd0;

      // R5: exact restart timing
      restart = 1'b1;
      step();
      step();
      check(sleeping === 1'b1, "R5", "asleep at k+1", int'(sleeping), 1);
      step();
      check(sleeping === 1'b0, "R5", "awake at k+2", int'(sleeping), 0);
      check(cpu_clk === 1'b0, "R5", "no pulse at k+2", int'(cpu_clk), 0);
      step();
      check(cpu_clk === 1'b1, "R5", "pulse at k+3", int'(cpu_clk), 1);
      restart = 1'b0;
      irq = 3'd7;
      step();
      check(wake_req === 1'b0, "R8", "wake when awake", int'(wake_req), 0);
      irq = 3'd0;

      // R3: 8-bit bus needs a third cycle
      wide = 1'b0;
      bus_cyc(lp, 1'b0, 3'd5);
      bus_cyc(lp + 24'd4, 1'b1, 3'd6);
      step();
      check(sleeping === 1'b0, "R3", "after second cycle", int'(sleeping), 0);
      check(cpu_clk === 1'b1, "R3", "clock after second", int'(cpu_clk), 1);
      bus_cyc(lp + 24'd5, 1'b1, 3'd6);
      expect_stop("R3");
      wake_up();
      wide = 1'b1;

      // R1: every function code and direction
      for (int f = 0; f < 8; f++) begin
         for (int r = 0; r < 2; r++) begin
            bus_cyc(lp, 1'(r), 3'(f));
            bus_cyc(lp + 24'd4, 1'b1, 3'd6);
            step();
            check(sleeping === ((f == 5) && (r == 0)), "R1", "fc/rw qualify",
                  int'(sleeping), int'((f == 5) && (r == 0)));
            if (sleeping) wake_up();
         end
      end

      // R1: each address bit must match
      for (int b = 0; b < 24; b++) begin
         bus_cyc(lp ^ (24'd1 << b), 1'b0, 3'd5);
         bus_cyc(lp + 24'd4, 1'b1, 3'd6);
         step();
         check(sleeping === 1'b0, "R1", "address bit flipped", int'(sleeping), 0);
      end

      // R1: extremes of the address range
      lp = 24'h000000;
      bus_cyc(lp, 1'b0, 3'd5);
      bus_cyc(24'h000400, 1'b1, 3'd6);
      step();
      check(sleeping === 1'b1, "R1", "lowest address", int'(sleeping), 1);
      wake_up();
      lp = 24'hFFFFFF;
      bus_cyc(lp, 1'b0, 3'd5);
      bus_cyc(24'h000400, 1'b1, 3'd6);
      step();
      check(sleeping === 1'b1, "R1", "highest address", int'(sleeping), 1);
      wake_up();
      lp = 24'hA53C0F;

      // R6: restart while idle, then while counting
      restart = 1'b1;
      repeat (4) begin
         step();
         check(cpu_clk === 1'b1 && sleeping === 1'b0, "R6", "restart idle",
               int'(cpu_clk), 1);
      end
      restart = 1'b0;
      bus_cyc(lp, 1'b0, 3'd5);
      restart = 1'b1;
      repeat (3) step();
      restart = 1'b0;
      step();
      bus_cyc(lp + 24'd4, 1'b1, 3'd6);
      expect_stop("R6");
      wake_up();

      // R7: reset drops a partly counted sequence
      bus_cyc(lp, 1'b0, 3'd5);
      rst_n = 1'b0;
      repeat (2) step();
      rst_n = 1'b1;
      repeat (3) step();
      bus_cyc(lp + 24'd4, 1'b1, 3'd6);
      step();
      check(sleeping === 1'b0, "R7", "sequence dropped", int'(sleeping), 0);

      // R7: reset while asleep
      bus_cyc(lp, 1'b0, 3'd5);
      bus_cyc(lp + 24'd4, 1'b1, 3'd6);
      expect_stop("R2");
      rst_n = 1'b0;
      #1;
      check(sleeping === 1'b0, "R7", "sleeping cleared", int'(sleeping), 0);
      step();
      check(cpu_clk === 1'b1, "R7", "clock resumes in reset", int'(cpu_clk), 1);
      rst_n = 1'b1;
      repeat (3) step();
      check(cpu_clk === 1'b1, "R7", "clock after release", int'(cpu_clk), 1);

      check(low_phase_bad == 0, "R9", "high during low phase", low_phase_bad, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule